// File: doc/BRIEF.md
# TLB Selective Invalidation Engine

This block keeps the tag side of a small, fully associative translation buffer and removes stale translations from it on command. Each entry holds a page-pair number, a per-entry page mask, a two-bit region code, a memory-map identifier, a global flag and a valid flag. A load port writes whole entries, and a combinational read port shows any entry. The block performs no address lookups.

An invalidation request carries a two-bit mode, a page-pair number, a region code and a map identifier. The request enters through a valid/ready handshake. Once accepted, the engine visits every entry in index order, one per clock, and clears the valid flag of each entry that matches under the selected mode. It then pulses `done`. The low entries, below a programmable wired count, are spared by the full flush and by no other mode.

Back-pressure rules: `req_ready` is low for the whole sweep. A request presented while `req_ready` is low is not taken, and the requester must hold it until `req_ready` is high at a clock edge. The wired count and all request fields are captured at the accepting edge. Entry writes are accepted only while the engine is idle.

Top module: `tlb_inval_engine`

## Requirements
- R1: After reset, every entry reads back with all fields zero and the valid flag clear. `busy` and `done` are low and `req_ready` is high.
- R2: While `busy` is low, a clock edge with `wr_en` high stores all fields of the entry at `wr_idx`, and the read port shows them. While `busy` is high, `wr_en` has no effect.
- R3: A request is taken on an edge where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle for exactly N_ENT cycles, and `req_ready` is low throughout. Requests presented during that window are ignored.
- R4: `done` is high for exactly one cycle: the first cycle after `busy` falls.
- R5: Mode code 0 (`req_mode` = 2'b00) clears every entry whose index is at least the wired count captured at acceptance. Entries below that count keep their valid flag.
- R6: Mode code 1 (2'b01) clears every entry whose address matches, whatever its identifier or global flag. An address match requires two things. First, the entry's page-pair number and the request's page-pair number must be equal after both are ANDed with the inverse of the entry's page mask. Second, the region codes must be equal. Bit 0 of the page-pair fields stands for virtual address bit 13.
- R7: Mode code 2 (2'b10) clears an entry only when its identifier equals the request identifier and its global flag is clear.
- R8: Mode code 3 (2'b11) clears an entry when its address matches (as in R6) and either its global flag is set or its identifier equals the request identifier.
- R9: In mode codes 1, 2 and 3, a matching entry below the wired count is cleared like any other.
- R10: A sweep changes only valid flags. Page numbers, masks, regions, identifiers and global flags stay as written, and entries that do not match keep their valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe (ignored while busy) |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VPN_W | Page-pair number to write |
| wr_mask | input | VPN_W | Page mask to write (1 = bit not compared) |
| wr_region | input | 2 | Region code to write |
| wr_mmid | input | MMID_W | Map identifier to write |
| wr_global | input | 1 | Global flag to write |
| wr_valid | input | 1 | Valid flag to write |
| rd_idx | input | IDX_W | Entry index to show on the read port |
| rd_vpn | output | VPN_W | Page-pair number of entry `rd_idx` |
| rd_mask | output | VPN_W | Page mask of entry `rd_idx` |
| rd_region | output | 2 | Region code of entry `rd_idx` |
| rd_mmid | output | MMID_W | Map identifier of entry `rd_idx` |
| rd_global | output | 1 | Global flag of entry `rd_idx` |
| rd_valid | output | 1 | Valid flag of entry `rd_idx` |
| wired_cnt | input | IDX_W+1 | Number of protected low entries, captured at acceptance |
| req_valid | input | 1 | Invalidation request present |
| req_ready | output | 1 | Engine can take a request |
| req_mode | input | 2 | Mode code: 0 all, 1 address, 2 identifier, 3 address and identifier |
| req_vpn | input | VPN_W | Request page-pair number |
| req_region | input | 2 | Request region code |
| req_mmid | input | MMID_W | Request map identifier |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the sweep ends |

## Verification
The bound checker watches the handshake and its timing on every cycle. It checks that an accepted request raises `busy` on the next cycle, that the sweep lasts exactly N_ENT cycles, and that `done` follows the fall of `busy` as a single-cycle pulse. The bench shows the parts that depend on entry contents. It covers which entries lose their valid flag in each mode, how page masks and region codes affect the address match, and how the global flag behaves in modes 2 and 3. It also checks that the wired count protects entries only in the full flush, that the other fields survive a sweep, and that writes and requests arriving mid-sweep have no effect.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;
  typedef enum logic [1:0] {
    INV_ALL   = 2'b00,
    INV_VA    = 2'b01,
    INV_ID    = 2'b10,
    INV_VA_ID = 2'b11
  } inv_mode_e;
endpackage

// File: rtl/tlb_tag_store.sv
module tlb_tag_store #(
  parameter int N_ENT  = 16,
  parameter int VPN_W  = 19,
  parameter int MMID_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [1:0]        wr_region,
  input  logic [MMID_W-1:0] wr_mmid,
  input  logic              wr_global,
  input  logic              wr_valid,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [VPN_W-1:0]  a_vpn,
  output logic [VPN_W-1:0]  a_mask,
  output logic [1:0]        a_region,
  output logic [MMID_W-1:0] a_mmid,
  output logic              a_global,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [VPN_W-1:0]  b_vpn,
  output logic [VPN_W-1:0]  b_mask,
  output logic [1:0]        b_region,
  output logic [MMID_W-1:0] b_mmid,
  output logic              b_global,
  output logic              b_valid
);
  logic [VPN_W-1:0]  vpn_q    [N_ENT];
  logic [VPN_W-1:0]  mask_q   [N_ENT];
  logic [1:0]        region_q [N_ENT];
  logic [MMID_W-1:0] mmid_q   [N_ENT];
  logic              glob_q   [N_ENT];
  logic              vld_q    [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(e));
    assign clr_hit = clr_en && (clr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vpn_q[e]    <= '0;
        mask_q[e]   <= '0;
        region_q[e] <= '0;
        mmid_q[e]   <= '0;
        glob_q[e]   <= 1'b0;
        vld_q[e]    <= 1'b0;
      end else if (wr_hit) begin
        vpn_q[e]    <= wr_vpn;
        mask_q[e]   <= wr_mask;
        region_q[e] <= wr_region;
        mmid_q[e]   <= wr_mmid;
        glob_q[e]   <= wr_global;
        vld_q[e]    <= wr_valid;
      end else if (clr_hit) begin
        vld_q[e]    <= 1'b0;
      end
    end
  end

  assign a_vpn    = vpn_q[a_idx];
  assign a_mask   = mask_q[a_idx];
  assign a_region = region_q[a_idx];
  assign a_mmid   = mmid_q[a_idx];
  assign a_global = glob_q[a_idx];

  assign b_vpn    = vpn_q[b_idx];
  assign b_mask   = mask_q[b_idx];
  assign b_region = region_q[b_idx];
  assign b_mmid   = mmid_q[b_idx];
  assign b_global = glob_q[b_idx];
  assign b_valid  = vld_q[b_idx];
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_inval_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int VPN_W  = 19,
  parameter int MMID_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  inv_mode_e         mode,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [1:0]        q_region,
  input  logic [MMID_W-1:0] q_mmid,
  input  logic [IDX_W:0]    q_wired,
  input  logic [IDX_W-1:0]  e_idx,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [VPN_W-1:0]  e_mask,
  input  logic [1:0]        e_region,
  input  logic [MMID_W-1:0] e_mmid,
  input  logic              e_global,
  output logic              hit
);
  logic va_eq, id_eq, above_wired;

  assign va_eq = ((e_vpn & ~e_mask) == (q_vpn & ~e_mask)) && (e_region == q_region);
  assign id_eq = (e_mmid == q_mmid);
  assign above_wired = ({1'b0, e_idx} >= q_wired);

  always_comb begin
    unique case (mode)
      INV_ALL:   hit = above_wired;
      INV_VA:    hit = va_eq;
      INV_ID:    hit = id_eq && !e_global;
      INV_VA_ID: hit = va_eq && (e_global || id_eq);
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_sweep_ctrl.sv
module tlb_sweep_ctrl
  import tlb_inval_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int VPN_W  = 19,
  parameter int MMID_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_region,
  input  logic [MMID_W-1:0] req_mmid,
  input  logic [IDX_W:0]    wired_cnt,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  ptr,
  output inv_mode_e         q_mode,
  output logic [VPN_W-1:0]  q_vpn,
  output logic [1:0]        q_region,
  output logic [MMID_W-1:0] q_mmid,
  output logic [IDX_W:0]    q_wired
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic take;
  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ptr      <= '0;
      q_mode   <= INV_ALL;
      q_vpn    <= '0;
      q_region <= '0;
      q_mmid   <= '0;
      q_wired  <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy     <= 1'b1;
        ptr      <= '0;
        q_mode   <= inv_mode_e'(req_mode);
        q_vpn    <= req_vpn;
        q_region <= req_region;
        q_mmid   <= req_mmid;
        q_wired  <= wired_cnt;
      end else if (busy) begin
        if (ptr == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          ptr  <= '0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
  import tlb_inval_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int VPN_W  = 19,
  parameter int MMID_W = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [1:0]        wr_region,
  input  logic [MMID_W-1:0] wr_mmid,
  input  logic              wr_global,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [VPN_W-1:0]  rd_mask,
  output logic [1:0]        rd_region,
  output logic [MMID_W-1:0] rd_mmid,
  output logic              rd_global,
  output logic              rd_valid,
  input  logic [IDX_W:0]    wired_cnt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_region,
  input  logic [MMID_W-1:0] req_mmid,
  output logic              busy,
  output logic              done
);
  logic [IDX_W-1:0]  ptr;
  inv_mode_e         q_mode;
  logic [VPN_W-1:0]  q_vpn;
  logic [1:0]        q_region;
  logic [MMID_W-1:0] q_mmid;
  logic [IDX_W:0]    q_wired;
  logic [VPN_W-1:0]  s_vpn, s_mask;
  logic [1:0]        s_region;
  logic [MMID_W-1:0] s_mmid;
  logic              s_global, s_hit;

  tlb_sweep_ctrl #(.N_ENT(N_ENT), .VPN_W(VPN_W), .MMID_W(MMID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_vpn(req_vpn), .req_region(req_region), .req_mmid(req_mmid),
    .wired_cnt(wired_cnt), .req_ready(req_ready), .busy(busy), .done(done),
    .ptr(ptr), .q_mode(q_mode), .q_vpn(q_vpn), .q_region(q_region),
    .q_mmid(q_mmid), .q_wired(q_wired)
  );

  tlb_tag_store #(.N_ENT(N_ENT), .VPN_W(VPN_W), .MMID_W(MMID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !busy), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_region(wr_region), .wr_mmid(wr_mmid), .wr_global(wr_global), .wr_valid(wr_valid),
    .clr_en(busy && s_hit), .clr_idx(ptr),
    .a_idx(ptr), .a_vpn(s_vpn), .a_mask(s_mask), .a_region(s_region),
    .a_mmid(s_mmid), .a_global(s_global),
    .b_idx(rd_idx), .b_vpn(rd_vpn), .b_mask(rd_mask), .b_region(rd_region),
    .b_mmid(rd_mmid), .b_global(rd_global), .b_valid(rd_valid)
  );

  tlb_entry_match #(.N_ENT(N_ENT), .VPN_W(VPN_W), .MMID_W(MMID_W)) u_match (
    .mode(q_mode), .q_vpn(q_vpn), .q_region(q_region), .q_mmid(q_mmid),
    .q_wired(q_wired), .e_idx(ptr), .e_vpn(s_vpn), .e_mask(s_mask),
    .e_region(s_region), .e_mmid(s_mmid), .e_global(s_global), .hit(s_hit)
  );
endmodule

// File: rtl/tlb_inval_checker.sv
module tlb_inval_checker #(
  parameter int N_ENT = 16,
  localparam int CW = $clog2(N_ENT) + 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done
);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_sweep_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CW'(N_ENT)));

  p_no_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_done_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind tlb_inval_engine tlb_inval_checker #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done)
);

// File: tb/sim_tlb_inval_engine.sv
module sim_tlb_inval_engine;
  localparam int N = 16;
  localparam int VW = 19;
  localparam int MW = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_global = 0, wr_valid = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [VW-1:0] wr_vpn = '0, wr_mask = '0, req_vpn = '0;
  logic [1:0] wr_region = '0, req_region = '0, req_mode = '0;
  logic [MW-1:0] wr_mmid = '0, req_mmid = '0;
  logic [IW:0] wired_cnt = '0;
  logic req_valid = 0;
  logic [VW-1:0] rd_vpn, rd_mask;
  logic [1:0] rd_region;
  logic [MW-1:0] rd_mmid;
  logic rd_global, rd_valid, req_ready, busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [VW-1:0] m_vpn [N];
  logic [VW-1:0] m_mask [N];
  logic [1:0] m_reg [N];
  logic [MW-1:0] m_id [N];
  logic m_g [N], m_v [N];

  always #2 clk = ~clk;

  tlb_inval_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_mask(wr_mask), .wr_region(wr_region), .wr_mmid(wr_mmid), .wr_global(wr_global),
    .wr_valid(wr_valid), .rd_idx(rd_idx), .rd_vpn(rd_vpn), .rd_mask(rd_mask),
    .rd_region(rd_region), .rd_mmid(rd_mmid), .rd_global(rd_global), .rd_valid(rd_valid),
    .wired_cnt(wired_cnt), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_vpn(req_vpn), .req_region(req_region),
    .req_mmid(req_mmid), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int i, input int r);
    @(negedge clk);
    m_vpn[i]  = VW'(19'h12340 | ((i ^ r) & 3));
    m_mask[i] = (i % 4 == 0) ? VW'(3) : VW'(0);
    m_reg[i]  = (i % 5 == 0) ? 2'd1 : 2'd0;
    m_id[i]   = MW'(16'hA000 + ((i + r) % 3));
    m_g[i]    = (i % 3 == 1);
    m_v[i]    = ((i + r) % 7 != 3);
    wr_en = 1; wr_idx = IW'(i); wr_vpn = m_vpn[i]; wr_mask = m_mask[i];
    wr_region = m_reg[i]; wr_mmid = m_id[i]; wr_global = m_g[i]; wr_valid = m_v[i];
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic bit exp_hit(input int i, input int md, input int wc,
                                 input logic [VW-1:0] qv, input logic [1:0] qr,
                                 input logic [MW-1:0] qm);
    bit va, id;
    va = ((m_vpn[i] & ~m_mask[i]) == (qv & ~m_mask[i])) && (m_reg[i] == qr);
    id = (m_id[i] == qm);
    case (md)
      0: return i >= wc;
      1: return va;
      2: return id && !m_g[i];
      default: return va && (m_g[i] || id);
    endcase
  endfunction

  task automatic check_entry(input int i, input string tag);
    rd_idx = IW'(i);
    #1;
    chk(tag, 32'(rd_valid), 32'(m_v[i]));
    chk("R10 fields", {rd_vpn[12:0], rd_mask[1:0], rd_region, rd_mmid[1:0], rd_global},
        {m_vpn[i][12:0], m_mask[i][1:0], m_reg[i], m_id[i][1:0], m_g[i]});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 ready", 32'(req_ready), 1);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i); #1;
      chk("R1 entry", {rd_valid, rd_global, 12'(rd_vpn), 8'(rd_mmid), rd_region, 4'(rd_mask)}, 0);
    end
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < 16; r++) begin
      int md, wc, n;
      logic [VW-1:0] qv;
      logic [1:0] qr;
      logic [MW-1:0] qm;
      md = r % 4;
      wc = (r == 4) ? 0 : (r == 8) ? N : (r == 12) ? N - 1 : (r * 5) % 7;
      qv = VW'(19'h12340 | (r & 3));
      qr = (r % 5 == 4) ? 2'd1 : 2'd0;
      qm = MW'(16'hA000 + (r % 3));
      for (int i = 0; i < N; i++) load(i, r);
      // R2 write port readback
      check_entry(r % N, "R2 load");

      @(negedge clk);
      req_valid = 1; req_mode = 2'(md); req_vpn = qv; req_region = qr; req_mmid = qm;
      wired_cnt = (IW+1)'(wc);
      @(negedge clk);
      req_valid = 0; wired_cnt = '0;
      chk("R3 busy after accept", 32'(busy), 1);
      chk("R3 ready low", 32'(req_ready), 0);
      n = 0;
      while (busy && n < 100) begin
        n++;
        if (n == 3) begin
          // R3 / R2: mid-sweep request and write must be ignored
          req_valid = 1; req_mode = 2'd0; req_vpn = '0; req_region = 2'd3; req_mmid = '0;
          wr_en = 1; wr_idx = IW'(N - 1); wr_vpn = 19'h7FFFF; wr_mask = '0;
          wr_region = 2'd3; wr_mmid = 16'h5555; wr_global = 1; wr_valid = 1;
        end
        if (n == 5) begin req_valid = 0; wr_en = 0; end
        @(negedge clk);
      end
      req_valid = 0; wr_en = 0;
      chk("R3 sweep length", 32'(n), 32'(N));
      chk("R4 done pulse", 32'(done), 1);
      for (int i = 0; i < N; i++) begin
        bit h;
        string tag;
        h = exp_hit(i, md, wc, qv, qr, qm);
        tag = (md == 0) ? "R5" : (md == 1) ? "R6" : (md == 2) ? "R7" : "R8";
        if (h && md != 0 && i < wc) tag = "R9 wired";
        if (!h) tag = "R10 untouched";
        if (h) m_v[i] = 0;
        check_entry(i, tag);
      end
      chk("R4 done low", 32'(done), 0);
      chk("R3 idle after sweep", 32'(busy), 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule